// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Override

This block shifts bytes out on a single asynchronous serial line, timed by an external base-clock tick that runs at 16 or 8 times the bit rate. A frame is a low start bit, 7 or 8 data bits sent least significant bit first, an optional slot carrying a caller-supplied parity level, and one or two high stop bits. Bytes arrive over a valid/ready handshake that only accepts data while transmission is enabled and the sender is idle.

Two port-control inputs take over the pin whenever transmission is disabled. One enables the pin driver and the other sets its level. With both at 1 the line holds mark before transmission starts. A break is sent by first driving the level input low and then dropping the enable, which cancels any frame in progress at once. With the driver enable at 0 the output-enable is released, so the pad can float.

Top module: `async_tx_break`

## Requirements
- R1: While `tx_en_i` is 0, `txd_oe_o` equals `port_oe_i`, and when `port_oe_i` is 1, `txd_o` equals `port_lvl_i` in the same cycle.
- R2: While `tx_en_i` is 1 and no frame is in progress, `txd_o` is 1, `txd_oe_o` is 1 and `ready_o` is 1.
- R3: A frame is bit 0 low (start), then `data_i[0]` upward: 8 data bits if `len7_i` is 0, 7 if it is 1. If `par_en_i` is 1, one slot at level `par_bit_i` follows. Then come 1 stop bit if `stop2_i` is 0, or 2 if it is 1, all high.
- R4: Each frame bit lasts exactly N cycles in which `tick_i` is 1, with N = 8 when `os8_i` is 1 and N = 16 when it is 0. Cycles without a tick do not advance the bit.
- R5: A byte is taken at a clock edge where `valid_i` and `ready_o` are both 1. Its start bit appears in the next cycle, `ready_o` stays 0 until the last stop bit has ended, and the configuration inputs are captured with the byte.
- R6: Clearing `tx_en_i` aborts a frame in progress in that same cycle. The line follows R1, and no part of the old frame is sent after re-enable.
- R7: `valid_i` asserted while `tx_en_i` is 0 is ignored and not queued. No frame starts when transmission is later enabled.
- R8: When `tx_en_i` returns to 1 after a break, `txd_o` is 1 and `ready_o` is 1 in the first cycle with the enable set.
- R9: With `port_oe_i` 1, first setting `port_lvl_i` to 0 and then clearing `tx_en_i` drives `txd_o` to 0 and keeps it there for as long as the enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; 0 aborts and hands the pin to the port bits |
| port_oe_i | input | 1 | Port driver enable used while disabled |
| port_lvl_i | input | 1 | Port line level used while disabled |
| tick_i | input | 1 | Base-clock tick, one cycle wide |
| os8_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| len7_i | input | 1 | 1: 7 data bits, 0: 8 data bits |
| par_en_i | input | 1 | Insert the parity slot |
| par_bit_i | input | 1 | Level of the parity slot |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Byte can be accepted |
| txd_o | output | 1 | Serial line |
| txd_oe_o | output | 1 | Line driver enable |

## Verification
A frame length, tick count or shift position that is wrong inside the block shows up on `txd_o` as a bit with the wrong level or the wrong duration. It also moves the cycle in which `ready_o` returns, and both are seen within one bit time of the error. An abort that fails to clear the sequencer shows in the first cycle after re-enable: the line goes low or `ready_o` stays 0 instead of idling at mark. A mux fault in the disabled path shows on the first sampled cycle of each port-bit combination.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 4;  // start + data + parity + 2 stop
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic os8;
    logic len7;
    logic par_en;
    logic par_bit;
    logic stop2;
  } tx_cfg_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } tx_frame_t;

  function automatic tx_frame_t build_frame(input tx_cfg_t cfg, input logic [DATA_W-1:0] d);
    tx_frame_t   f;
    int unsigned idx;
    f.bits = '1;
    f.bits[0] = 1'b0;
    idx = 1;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (!(cfg.len7 && i == DATA_W - 1)) begin
        f.bits[idx] = d[i];
        idx++;
      end
    end
    if (cfg.par_en) begin
      f.bits[idx] = cfg.par_bit;
      idx++;
    end
    idx = idx + (cfg.stop2 ? 2 : 1);
    f.len = LEN_W'(idx);
    return f;
  endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int unsigned OS_HI = 16,
  parameter int unsigned OS_LO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic os8_i,
  output logic bit_end_o
);
  localparam int unsigned CW = $clog2(OS_HI);
  localparam logic [CW-1:0] LAST_HI = CW'(OS_HI - 1);
  localparam logic [CW-1:0] LAST_LO = CW'(OS_LO - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last      = os8_i ? LAST_LO : LAST_HI;
  assign bit_end_o = run_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end

  // tick count never passes the selected ratio
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  a_r4_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);

endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
  import async_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  tx_cfg_t           cfg_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit_end_i,
  output logic              busy_o,
  output logic              os8_o,
  output logic              bit_o
);
  tx_frame_t          nxt;
  logic [FRAME_W-1:0] sr_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q;
  logic               os8_q;

  assign nxt = build_frame(cfg_i, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      os8_q  <= 1'b0;
    end else if (!en_i) begin
      // abort regardless of progress
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= nxt.bits;
      left_q <= nxt.len;
      busy_q <= 1'b1;
      os8_q  <= cfg_i.os8;
    end else if (busy_q && bit_end_i) begin
      sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
      if (left_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign os8_o  = os8_q;
  assign bit_o  = sr_q[0];

  a_r6_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_q);
  a_r5_load_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> busy_q && !sr_q[0]);
  a_r3_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0) && (left_q <= LEN_W'(FRAME_W)));

endmodule

// File: rtl/tx_pin_mux.sv
module tx_pin_mux (
  input  logic tx_en_i,
  input  logic port_oe_i,
  input  logic port_lvl_i,
  input  logic busy_i,
  input  logic bit_i,
  output logic txd_o,
  output logic txd_oe_o
);
  always_comb begin
    if (tx_en_i) begin
      txd_o    = busy_i ? bit_i : 1'b1;
      txd_oe_o = 1'b1;
    end else begin
      txd_o    = port_oe_i ? port_lvl_i : 1'b1;
      txd_oe_o = port_oe_i;
    end
  end
endmodule

// File: rtl/async_tx_break.sv
module async_tx_break
  import async_tx_pkg::*;
#(
  parameter int unsigned OS_HI = 16,
  parameter int unsigned OS_LO = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              port_oe_i,
  input  logic              port_lvl_i,
  input  logic              tick_i,
  input  logic              os8_i,
  input  logic              len7_i,
  input  logic              par_en_i,
  input  logic              par_bit_i,
  input  logic              stop2_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              txd_oe_o
);
  tx_cfg_t cfg;
  logic    busy;
  logic    os8_q;
  logic    bit_end;
  logic    sr_bit;
  logic    load;

  assign cfg     = '{os8: os8_i, len7: len7_i, par_en: par_en_i, par_bit: par_bit_i, stop2: stop2_i};
  assign ready_o = tx_en_i && !busy;
  assign load    = valid_i && ready_o;

  tx_bit_timer #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy && tx_en_i),
    .tick_i   (tick_i),
    .os8_i    (os8_q),
    .bit_end_o(bit_end)
  );

  tx_frame_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tx_en_i),
    .load_i   (load),
    .cfg_i    (cfg),
    .data_i   (data_i),
    .bit_end_i(bit_end),
    .busy_o   (busy),
    .os8_o    (os8_q),
    .bit_o    (sr_bit)
  );

  tx_pin_mux u_mux (
    .tx_en_i   (tx_en_i),
    .port_oe_i (port_oe_i),
    .port_lvl_i(port_lvl_i),
    .busy_i    (busy),
    .bit_i     (sr_bit),
    .txd_o     (txd_o),
    .txd_oe_o  (txd_oe_o)
  );

  a_r2_idle_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !busy) |-> txd_o && txd_oe_o);
  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $rose(busy)) |-> !txd_o);
  a_r7_no_accept_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !ready_o);
  a_r8_reenable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_i) |-> ready_o && txd_o);

endmodule

// File: tb/async_tx_break_test.sv
`timescale 1ns/1ps
module async_tx_break_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, port_oe = 1'b1, port_lvl = 1'b1, tick = 1'b1;
  logic       os8 = 1'b0, len7 = 1'b0, par_en = 1'b0, par_bit = 1'b0, stop2 = 1'b0;
  logic [7:0] data = 8'h00;
  logic       valid = 1'b0;
  logic       ready, txd, txd_oe;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  async_tx_break uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .port_oe_i(port_oe), .port_lvl_i(port_lvl),
    .tick_i(tick), .os8_i(os8), .len7_i(len7), .par_en_i(par_en), .par_bit_i(par_bit),
    .stop2_i(stop2), .data_i(data), .valid_i(valid), .ready_o(ready), .txd_o(txd), .txd_oe_o(txd_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nd(input bit l7); return l7 ? 7 : 8; endfunction
  function automatic int flen(input bit l7, input bit pe, input bit s2);
    return 1 + nd(l7) + (pe ? 1 : 0) + (s2 ? 2 : 1);
  endfunction
  function automatic bit exp_bit(input int j, input bit l7, input bit pe, input bit pb, input logic [7:0] d);
    if (j == 0) return 1'b0;
    if (j <= nd(l7)) return d[j-1];
    if (pe && j == nd(l7) + 1) return pb;
    return 1'b1;
  endfunction

  // R3 R4 R5: full frame with tick every cycle
  task automatic send_check(input bit o8, input bit l7, input bit pe, input bit pb, input bit s2, input logic [7:0] d);
    int n, len, bad, rbad, first_bad, act_bad;
    n = o8 ? 8 : 16;
    len = flen(l7, pe, s2);
    bad = 0; rbad = 0; first_bad = -1; act_bad = 0;
    @(posedge clk); #1;
    os8 = o8; len7 = l7; par_en = pe; par_bit = pb; stop2 = s2; data = d; valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0;
    // scramble config after acceptance (R5)
    os8 = ~o8; len7 = ~l7; par_en = ~pe; par_bit = ~pb; stop2 = ~s2; data = ~d;
    for (int i = 0; i < len * n; i++) begin
      @(negedge clk);
      if (txd !== exp_bit(i / n, l7, pe, pb, d)) begin
        if (first_bad < 0) begin first_bad = i; act_bad = txd; end
        bad++;
      end
      if (ready !== 1'b0) rbad++;
    end
    check(bad == 0, "R3/R4 frame bits", first_bad, -1);
    check(rbad == 0, "R5 ready low during frame", rbad, 0);
    @(negedge clk);
    check(ready === 1'b1 && txd === 1'b1, "R2 R5 idle after last stop", {ready, txd}, 3);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state, R1
    #5;
    check(txd === 1'b1 && txd_oe === 1'b1 && ready === 1'b0, "R1 reset mark", {txd, txd_oe, ready}, 6);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: all port combinations while disabled
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      port_oe = k[1]; port_lvl = k[0];
      @(negedge clk);
      check(txd_oe === port_oe && (!port_oe || txd === port_lvl), "R1 port override",
            {txd_oe, txd}, {port_oe, port_lvl});
    end

    // R7: valid while disabled is dropped
    @(posedge clk); #1;
    port_oe = 1'b1; port_lvl = 1'b1; data = 8'h00; valid = 1'b1;
    repeat (20) @(posedge clk);
    #1 valid = 1'b0;
    @(posedge clk); #1 tx_en = 1'b1;
    begin
      int bad7 = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || ready !== 1'b1 || txd_oe !== 1'b1) bad7++;
      end
      check(bad7 == 0, "R7 R2 no queued frame", bad7, 0);
    end

    // R3 R4 R5 sweep over every configuration
    for (int c = 0; c < 16; c++) begin
      send_check(c[0], c[1], c[2], c[3], c[3] ^ c[2], 8'hA5 ^ 8'(c * 17));
      send_check(c[0], c[1], c[2], ~c[3], c[1], 8'h3C + 8'(c));
    end
    send_check(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    send_check(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);

    // R4: no ticks, no progress
    @(posedge clk); #1;
    tick = 1'b0; os8 = 1'b1; len7 = 1'b0; par_en = 1'b0; stop2 = 1'b0; data = 8'hFF; valid = 1'b1;
    @(posedge clk); #1 valid = 1'b0;
    begin
      int bad4 = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (txd !== 1'b0) bad4++;
      end
      check(bad4 == 0, "R4 stall without tick", bad4, 0);
    end
    @(posedge clk); #1 tx_en = 1'b0; tick = 1'b1;
    @(posedge clk); #1 tx_en = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && ready === 1'b1, "R6 abort while stalled", {txd, ready}, 3);

    // R6 R9: break mid-frame
    @(posedge clk); #1;
    os8 = 1'b0; len7 = 1'b0; par_en = 1'b0; stop2 = 1'b0; data = 8'hFF; valid = 1'b1;
    @(posedge clk); #1 valid = 1'b0;
    repeat (40) @(posedge clk);
    #1 port_lvl = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R6 frame unaffected by port level", txd, 1);
    @(posedge clk); #1 tx_en = 1'b0;
    @(negedge clk);
    check(txd === 1'b0 && txd_oe === 1'b1 && ready === 1'b0, "R6 R9 break at once",
          {txd, txd_oe, ready}, 2);
    begin
      int bad9 = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (txd !== 1'b0) bad9++;
      end
      check(bad9 == 0, "R9 break held", bad9, 0);
    end
    // R8: re-enable returns mark at once
    @(posedge clk); #1 tx_en = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && ready === 1'b1, "R8 mark on re-enable", {txd, ready}, 3);
    @(posedge clk); #1 port_lvl = 1'b1;
    begin
      int bad6 = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (txd !== 1'b1) bad6++;
      end
      check(bad6 == 0, "R6 no remnant of aborted frame", bad6, 0);
    end
    send_check(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A);

    // R1: released pin after disable
    @(posedge clk); #1 port_oe = 1'b0; tx_en = 1'b0;
    @(negedge clk);
    check(txd_oe === 1'b0, "R1 pin released", txd_oe, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule